// File: doc/BRIEF.md
# Delayed One-Shot Pulse Generator

This block makes a single output pulse after a programmable delay, each time it is triggered. It has two down-counting channels in a chain. The first channel is the delay counter. A selected edge on the external trigger pin, or a software start strobe, loads the delay counter with the delay value. When the delay counter reaches zero it raises an end-of-delay event. That event loads the second channel, the width counter, with the width value. The pulse output is active while the width counter runs.

Software arms the block with a start strobe and disarms it with a stop strobe. Both strobes act on the two channels in the same cycle. Stopping freezes both counts and leaves the pulse pin at its present level. Delay and width are captured when the block is armed, so a running pulse train cannot be disturbed by new values. The trigger edge selection can still be changed while the block runs. All counting advances only on cycles where the count enable is high. A prescaler can drive that enable.

Top module: `dpg_top`

## Requirements
- R1: After reset `running`, `master_evt` and `slave_evt` are 0, both counts read 0, and with `out_en`=1 `pulse_out` shows the inactive level (the inverse of `ACT_LVL`).
- R2: A `start_stb` while disarmed sets `running` and arms the delay counter without loading it. A `start_stb` while armed is a software trigger: it loads the delay counter at that clock edge.
- R3: `edge_sel` encodes 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. `trig_in` passes a two-flop synchronizer, so a selected edge driven before clock edge k loads the delay counter at edge k+2. Edges of an unselected kind do nothing.
- R4: Once loaded with D, the delay counter counts down on each enabled tick. On the (D+1)-th tick it finds zero and asserts `master_evt` for exactly one cycle, and then it halts.
- R5: `master_evt` loads the width counter with W. `pulse_out` goes active at the first tick after the event and returns inactive W ticks later, when the width counter is found at zero. At that point `slave_evt` pulses for one cycle. A width of 0 gives no pulse.
- R6: Trigger edges and software triggers that arrive while the delay counter is busy are ignored. The delay is not restarted.
- R7: While armed, every later valid trigger repeats the delay-then-pulse sequence without re-arming.
- R8: `stop_stb` clears `running` in one cycle and wins over a simultaneous `start_stb`. Both counts keep their values, and `pulse_out` keeps its current level. Triggers are ignored until the block is armed again.
- R9: `delay_val` and `width_val` are sampled only by a `start_stb` that arms the block. Changes while armed have no effect, but `edge_sel` takes effect at once.
- R10: With `out_en`=0, `pulse_out` equals `idle_lvl` whatever the pulse state is.
- R11: With `cnt_en` high one cycle in P, an active pulse lasts W*P cycles. The pulse goes active P+1 sample cycles after `master_evt` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count tick enable |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| edge_sel | input | 2 | Trigger edge select |
| start_stb | input | 1 | Arm strobe / software trigger |
| stop_stb | input | 1 | Disarm strobe |
| delay_val | input | CW | Delay count |
| width_val | input | CW | Pulse width count |
| out_en | input | 1 | Pulse drives pin when high |
| idle_lvl | input | 1 | Pin level while output disabled |
| pulse_out | output | 1 | Pulse pin |
| master_evt | output | 1 | End-of-delay event |
| slave_evt | output | 1 | End-of-pulse event |
| master_cnt | output | CW | Delay counter value |
| slave_cnt | output | CW | Width counter value |
| running | output | 1 | Channels armed |

## Verification
The bench sweeps small delays and widths, including 0, through the trigger pin and through software start. It checks the exact event cycle, pulse start and pulse length against arithmetic built from the synchronizer latency. An off-by-one on either counter, or a missing synchronizer stage, moves these counts. The bench also runs a divided count enable; a design that counts on every clock would make pulses too short there. It retriggers mid-delay, where a design that reloads would move the event late. It changes delay and width while armed, where a design without capture would use the new values. It stops during a pulse, where a reinitialising design would drop the pin or clear the counts. Finally it drives edges of the unselected polarity, which must not fire.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/dpg_trig_detect.sv
module dpg_trig_detect
  import dpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] edge_sel,
  output logic       trig_edge
);
  // [0],[1]: synchronizer stages, [2]: previous synchronized level
  logic [2:0] sh_q, sh_d;
  edge_sel_e  sel;
  logic       rise, fall;

  always_comb begin
    sh_d = {sh_q[1:0], trig_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sel  = edge_sel_e'(edge_sel);
  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];

  always_comb begin
    case (sel)
      EDGE_RISE: trig_edge = rise;
      EDGE_FALL: trig_edge = fall;
      EDGE_BOTH: trig_edge = rise | fall;
      default:   trig_edge = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpg_down_chan.sv
module dpg_down_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          tick,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          zero_evt
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    zero_evt = 1'b0;
    if (!en) begin
      busy_d = 1'b0;
    end else if (load) begin
      cnt_d  = load_val;
      busy_d = 1'b1;
    end else if (busy_q && tick) begin
      if (cnt_q == '0) begin
        busy_d   = 1'b0;
        zero_evt = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign cnt  = cnt_q;
  assign busy = busy_q;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q)); // R11
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> ($stable(cnt_q) && !busy_q)); // R8
  AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> !busy_q); // R4
endmodule

// File: rtl/dpg_top.sv
module dpg_top #(
  parameter int CW      = 16,
  parameter bit ACT_LVL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          trig_in,
  input  logic [1:0]    edge_sel,
  input  logic          start_stb,
  input  logic          stop_stb,
  input  logic [CW-1:0] delay_val,
  input  logic [CW-1:0] width_val,
  input  logic          out_en,
  input  logic          idle_lvl,
  output logic          pulse_out,
  output logic          master_evt,
  output logic          slave_evt,
  output logic [CW-1:0] master_cnt,
  output logic [CW-1:0] slave_cnt,
  output logic          running
);
  logic          run_q, run_d;
  logic [CW-1:0] dly_q, dly_d, wid_q, wid_d;
  logic          pl_q, pl_d;
  logic          chan_en, arm, sw_trig, trig_edge;
  logic          m_load, m_busy, s_busy;

  assign chan_en = run_q & ~stop_stb;
  assign arm     = start_stb & ~run_q & ~stop_stb;
  assign sw_trig = start_stb & run_q;
  assign m_load  = chan_en & ~m_busy & (trig_edge | sw_trig);

  // arm/disarm and configuration capture
  always_comb begin
    run_d = run_q;
    dly_d = dly_q;
    wid_d = wid_q;
    if (stop_stb) begin
      run_d = 1'b0;
    end else if (arm) begin
      run_d = 1'b1;
      dly_d = delay_val;
      wid_d = width_val;
    end
  end

  // pulse level: updated on width-counter ticks only
  always_comb begin
    pl_d = pl_q;
    if (chan_en && s_busy && cnt_en && !master_evt)
      pl_d = (slave_cnt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      dly_q <= '0;
      wid_q <= '0;
      pl_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      dly_q <= dly_d;
      wid_q <= wid_d;
      pl_q  <= pl_d;
    end
  end

  dpg_trig_detect u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_in   (trig_in),
    .edge_sel  (edge_sel),
    .trig_edge (trig_edge)
  );

  dpg_down_chan #(.CW(CW)) u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chan_en),
    .load     (m_load),
    .tick     (cnt_en),
    .load_val (dly_q),
    .cnt      (master_cnt),
    .busy     (m_busy),
    .zero_evt (master_evt)
  );

  dpg_down_chan #(.CW(CW)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (chan_en),
    .load     (master_evt),
    .tick     (cnt_en),
    .load_val (wid_q),
    .cnt      (slave_cnt),
    .busy     (s_busy),
    .zero_evt (slave_evt)
  );

  assign running   = run_q;
  assign pulse_out = out_en ? (pl_q ? ACT_LVL : ~ACT_LVL) : idle_lvl;

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> !master_evt); // R4
  AST_EVT_LOADS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |=> s_busy); // R5
  AST_FALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pl_q) |-> $past(slave_evt)); // R5
  AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    master_evt |-> cnt_en); // R11
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !run_q); // R8
endmodule

// File: tb/dpg_top_tb_top.sv
module dpg_top_tb_top;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b1;
  logic          trig_in = 1'b0;
  logic [1:0]    edge_sel = 2'b11;
  logic          start_stb = 1'b0;
  logic          stop_stb = 1'b0;
  logic [CW-1:0] delay_val = '0;
  logic [CW-1:0] width_val = '0;
  logic          out_en = 1'b1;
  logic          idle_lvl = 1'b0;
  logic          pulse_out, master_evt, slave_evt, running;
  logic [CW-1:0] master_cnt, slave_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int per = 1;
  int ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (ph >= per - 1) ph = 0;
    else ph = ph + 1;
    cnt_en = (ph == 0);
  end

  dpg_top #(.CW(CW), .ACT_LVL(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .trig_in(trig_in),
    .edge_sel(edge_sel), .start_stb(start_stb), .stop_stb(stop_stb),
    .delay_val(delay_val), .width_val(width_val), .out_en(out_en),
    .idle_lvl(idle_lvl), .pulse_out(pulse_out), .master_evt(master_evt),
    .slave_evt(slave_evt), .master_cnt(master_cnt), .slave_cnt(slave_cnt),
    .running(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // disarm, load new configuration, arm again
  task automatic session(input int d, input int w);
    @(negedge clk); stop_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0; delay_val = CW'(d); width_val = CW'(w); start_stb = 1'b1;
    @(negedge clk); start_stb = 1'b0;
    #1 chk(running == 1'b1, "R2 armed", running, 1);
    chk(master_evt == 1'b0, "R2 arm does not trigger", master_evt, 0);
  endtask

  // one trigger, measure event and pulse timing (sample n = cycles after drive)
  task automatic run_one(input bit sw, input int d, input int w, input int p);
    int evt_n = -1, evt_cnt = 0, rise_n = -1, hi = 0, sevt_n = -1;
    int lim = (d + w + 4) * p + 12;
    @(negedge clk);
    if (sw) start_stb = 1'b1; else trig_in = ~trig_in;
    for (int n = 1; n <= lim; n++) begin
      @(negedge clk);
      start_stb = 1'b0;
      #1;
      if (master_evt) begin evt_cnt++; if (evt_n < 0) evt_n = n; end
      if (pulse_out) begin hi++; if (rise_n < 0) rise_n = n; end
      if (slave_evt && sevt_n < 0) sevt_n = n;
    end
    chk(evt_cnt == 1, "R4 single master event", evt_cnt, 1);
    if (p == 1) begin
      if (sw) chk(evt_n == d + 1, "R2 software trigger delay", evt_n, d + 1);
      else    chk(evt_n == d + 3, "R3 pin trigger delay", evt_n, d + 3);
    end
    if (p == 1) chk(hi == w, "R5 pulse width", hi, w);
    else        chk(hi == w * p, "R11 pulse width with divided tick", hi, w * p);
    if (w > 0) chk(rise_n - evt_n == p + 1, "R5 R11 pulse start", rise_n - evt_n, p + 1);
    chk(sevt_n - evt_n == p * (w + 1), "R5 end event", sevt_n - evt_n, p * (w + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int ec;
    logic [CW-1:0] sc, mc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(running == 1'b0, "R1 running", running, 0);
    chk(pulse_out == 1'b0, "R1 pulse inactive", pulse_out, 0);
    chk(master_evt == 1'b0 && slave_evt == 1'b0, "R1 events", master_evt, 0);
    chk(master_cnt == 0 && slave_cnt == 0, "R1 counts", master_cnt, 0);

    // R3 R4 R5 R7: sweep, two triggers per session (second repeats, R7)
    for (int d = 0; d <= 4; d++)
      for (int w = 0; w <= 4; w++) begin
        session(d, w);
        run_one(1'b0, d, w, 1);
        run_one(1'b0, d, w, 1);
      end

    // R2 software trigger while armed
    for (int d = 0; d <= 3; d++) begin
      session(d, 2);
      run_one(1'b1, d, 2, 1);
    end

    // R11 divided count enable
    per = 3;
    for (int w = 1; w <= 3; w++) begin
      session(2, w);
      run_one(1'b0, 2, w, 3);
    end
    per = 1;
    repeat (4) @(negedge clk);

    // R9 config locked while armed
    session(3, 2);
    delay_val = 16'd9; width_val = 16'd6;
    run_one(1'b0, 3, 2, 1);

    // R3 R9 edge selection live: falling only
    edge_sel = 2'b00;
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    edge_sel = 2'b10;
    trig_in = 1'b1;
    ec = 0;
    for (int n = 0; n < 15; n++) begin @(negedge clk); #1; if (master_evt) ec++; end
    chk(ec == 0, "R3 rising edge ignored by falling select", ec, 0);
    run_one(1'b0, 3, 2, 1);
    edge_sel = 2'b00;
    trig_in = 1'b1;
    ec = 0;
    for (int n = 0; n < 15; n++) begin @(negedge clk); #1; if (master_evt) ec++; end
    chk(ec == 0, "R3 no edge selected", ec, 0);
    edge_sel = 2'b11;

    // R6 retrigger during delay ignored
    session(8, 2);
    ec = 0; sc = '0;
    @(negedge clk); trig_in = ~trig_in;
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk); #1;
      if (master_evt) begin ec++; sc = CW'(n); end
      if (n == 3) trig_in = ~trig_in;
      if (n == 5) start_stb = 1'b1;
      if (n == 6) start_stb = 1'b0;
    end
    chk(ec == 1, "R6 single event on retrigger", ec, 1);
    chk(sc == 11, "R6 delay not restarted", sc, 11);

    // R8 stop mid-pulse
    session(2, 20);
    @(negedge clk); trig_in = ~trig_in;
    repeat (10) @(negedge clk);
    stop_stb = 1'b1; start_stb = 1'b1;
    @(negedge clk); stop_stb = 1'b0; start_stb = 1'b0;
    #1;
    chk(running == 1'b0, "R8 stop wins over start", running, 0);
    chk(pulse_out == 1'b1, "R8 level held", pulse_out, 1);
    sc = slave_cnt; mc = master_cnt;
    chk(sc != 0, "R8 width count frozen mid-pulse", sc, 1);
    trig_in = ~trig_in;
    ec = 0;
    for (int n = 0; n < 12; n++) begin @(negedge clk); #1; if (master_evt) ec++; end
    chk(slave_cnt == sc, "R8 width count held", slave_cnt, sc);
    chk(master_cnt == mc, "R8 delay count held", master_cnt, mc);
    chk(pulse_out == 1'b1, "R8 level still held", pulse_out, 1);
    chk(ec == 0, "R8 trigger ignored when stopped", ec, 0);

    // R10 output disable selects idle level (pulse state is active here)
    out_en = 1'b0; idle_lvl = 1'b0;
    #1 chk(pulse_out == 1'b0, "R10 idle low", pulse_out, 0);
    idle_lvl = 1'b1;
    #1 chk(pulse_out == 1'b1, "R10 idle high", pulse_out, 1);
    out_en = 1'b1;

    finish_run();
  end
endmodule